// File: doc/BRIEF.md
# Accumulator Multicycle CPU Core

A 16-bit accumulator processor that runs each instruction as a sequence of single-cycle steps. Every memory read and every memory write gets a step of its own. It drives a word-addressed synchronous memory with 4096 locations. The memory has a registered read: the address presented in one cycle returns its data in the next cycle. The core also has an 8-bit input port with a valid flag and an 8-bit output port with a one-cycle strobe.

Each instruction word holds a 4-bit operation code and a 12-bit direct address. The instruction set has the following groups:

- Direct loads, stores and arithmetic.
- A conditional skip.
- Jumps, including a call that writes its return address into memory and an indirect jump used to return.
- Indirect load, store and add, each of which reads a pointer first.
- Accumulator clear, port input and port output.
- A halt that freezes the core until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and right after it, `mem_we`, `out_strobe` and `halted` are 0, `mem_addr` is 0, and the first instruction is fetched from address 0.
- R2: Bits 15:12 of an instruction select the operation and bits 11:0 give the address X. The codes are:

  | Code | Operation |
  |------|-----------|
  | 0 | call (JnS) |
  | 1 | load |
  | 2 | store |
  | 3 | add |
  | 4 | subtract |
  | 5 | input |
  | 6 | output |
  | 7 | halt |
  | 8 | skip |
  | 9 | jump |
  | A | clear |
  | B | indirect add |
  | C | indirect jump |
  | D | indirect load |
  | E | indirect store |
  | F | no operation |

- R3: Load sets AC to M[X]. Store writes AC to M[X]. Add and subtract combine AC with M[X] and wrap modulo 2^16.
- R4: Skip adds one to PC when one of these holds: bits 11:10 are 00 and AC is negative; bits 11:10 are 01 and AC is zero; bits 11:10 are 10 and AC is positive. Code 11 never skips.
- R5: Jump sets PC to X. Call writes the address of the next instruction to M[X] and continues at X+1. Indirect jump sets PC to M[X].
- R6: Indirect load, add and store use M[X] bits 11:0 as the operand address. Indirect store writes AC to that address.
- R7: Input stalls until `in_valid` is 1, then loads AC with `in_data` zero-extended to 16 bits.
- R8: Output drives AC bits 7:0 on `out_data`, with `out_strobe` high for exactly one cycle.
- R9: After halt, `halted` stays 1, no memory write occurs and `mem_addr` stays stable until reset.
- R10: Clear sets AC to 0. Code F changes nothing except PC.
- R11: A write holds `mem_we` high for one cycle, with `mem_addr` and `mem_wdata` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| in_data | input | 8 | Input port data |
| in_valid | input | 1 | Input port data present |
| out_data | output | 8 | Output port data |
| out_strobe | output | 1 | Output port data new this cycle |
| halted | output | 1 | Core stopped by halt |

## Verification
A wrong PC, AC or pointer value shows up at the ports at the next memory write or output strobe. It appears either as a write to the wrong address or as a wrong data value. A skip or jump that goes wrong shows up as a missing or extra write, or as a wrong final memory image.

Each write and each strobe is compared against an instruction-level model as it happens. A divergence is therefore reported within one instruction of the point where it becomes visible. Faults that stay hidden inside the core are caught later, by the final memory image.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int IOW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [IOW-1:0] in_data,
  input  logic          in_valid,
  output logic [IOW-1:0] out_data,
  output logic          out_strobe,
  output logic          halted
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_JNS = 4'h0, OP_LOAD = 4'h1, OP_STORE = 4'h2, OP_ADD = 4'h3,
    OP_SUBT = 4'h4, OP_IN = 4'h5, OP_OUT = 4'h6, OP_HALT = 4'h7, OP_SKIP = 4'h8,
    OP_JUMP = 4'h9, OP_CLR = 4'hA, OP_ADDI = 4'hB, OP_JMPI = 4'hC, OP_LDI = 4'hD,
    OP_STI = 4'hE;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_R1, S_R2, S_I0, S_I1, S_I2,
    S_EX, S_ST0, S_ST1, S_J0, S_J1, S_IN, S_OUT, S_HALT
  } st_t;

  st_t state;
  logic [DW-1:0]  ac, mbr, ir;
  logic [AW-1:0]  pc, mar;
  logic [IOW-1:0] inreg, outreg;
  logic           strobe_q;

  wire [OPW-1:0] rop = mem_rdata[DW-1:AW];
  wire [OPW-1:0] op  = ir[DW-1:AW];
  wire [1:0]     sel = mem_rdata[AW-1:AW-2];
  wire           ac_neg  = ac[DW-1];
  wire           ac_zero = (ac == '0);
  wire           skip = (sel == 2'b00 && ac_neg) ||
                        (sel == 2'b01 && ac_zero) ||
                        (sel == 2'b10 && !ac_neg && !ac_zero);
  wire           ind = (op == OP_LDI) || (op == OP_ADDI) || (op == OP_STI);

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign mem_we     = (state == S_ST1) || (state == S_J1);
  assign out_data   = outreg;
  assign out_strobe = strobe_q;
  assign halted     = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_F0;
      ac       <= '0;
      mbr      <= '0;
      ir       <= '0;
      pc       <= '0;
      mar      <= '0;
      inreg    <= '0;
      outreg   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      unique case (state)
        S_F0: begin
          mar   <= pc;
          state <= S_F1;
        end
        S_F1: begin
          pc    <= pc + 1'b1;
          state <= S_F2;
        end
        S_F2: begin
          ir    <= mem_rdata;
          mar   <= mem_rdata[AW-1:0];
          state <= S_F0;
          case (rop)
            OP_LOAD, OP_ADD, OP_SUBT, OP_LDI, OP_ADDI, OP_STI, OP_JMPI: state <= S_R1;
            OP_STORE: state <= S_ST0;
            OP_JNS:   state <= S_J0;
            OP_IN:    state <= S_IN;
            OP_OUT:   state <= S_OUT;
            OP_HALT:  state <= S_HALT;
            OP_SKIP:  if (skip) pc <= pc + 1'b1;
            OP_JUMP:  pc <= mem_rdata[AW-1:0];
            OP_CLR:   ac <= '0;
            default:  ;
          endcase
        end
        S_R1: state <= S_R2;
        S_R2: begin
          mbr   <= mem_rdata;
          state <= ind ? S_I0 : S_EX;
        end
        S_I0: begin
          mar   <= mbr[AW-1:0];
          state <= (op == OP_STI) ? S_ST0 : S_I1;
        end
        S_I1: state <= S_I2;
        S_I2: begin
          mbr   <= mem_rdata;
          state <= S_EX;
        end
        S_EX: begin
          case (op)
            OP_LOAD, OP_LDI: ac <= mbr;
            OP_ADD, OP_ADDI: ac <= ac + mbr;
            OP_SUBT:         ac <= ac - mbr;
            OP_JMPI:         pc <= mbr[AW-1:0];
            default:         ;
          endcase
          state <= S_F0;
        end
        S_ST0: begin
          mbr   <= ac;
          state <= S_ST1;
        end
        S_ST1: state <= S_F0;
        S_J0: begin
          mbr   <= {{(DW-AW){1'b0}}, pc};
          state <= S_J1;
        end
        S_J1: begin
          pc    <= mar + 1'b1;
          state <= S_F0;
        end
        S_IN: if (in_valid) begin
          inreg <= in_data;
          ac    <= {{(DW-IOW){1'b0}}, in_data};
          state <= S_F0;
        end
        S_OUT: begin
          outreg   <= ac[IOW-1:0];
          strobe_q <= 1'b1;
          state    <= S_F0;
        end
        S_HALT: ;
        default: state <= S_F0;
      endcase
    end
  end

  // R11
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R2
  write_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (op == OP_STORE || op == OP_STI || op == OP_JNS));
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(mem_addr)));
  // R8
  out_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> (out_data == ac[IOW-1:0]));
  // R1
  fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F1) |=> (pc == $past(pc) + 1'b1));
endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  logic        clk = 0, rst_n = 0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  in_data = 8'h00, out_data;
  logic        in_valid = 0, out_strobe, halted;

  always #10 clk = ~clk;

  acc_cpu dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_strobe(out_strobe), .halted(halted));

  logic [15:0] mem [0:4095];
  logic [15:0] mm  [0:4095];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int checks = 0, fails = 0;
  int exp_wa[$];
  logic [15:0] exp_wd[$];
  logic [7:0]  exp_out[$];
  int outs_seen = 0;
  bit mon_en = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  always @(negedge clk) if (mon_en) begin
    if (mem_we) begin
      if (exp_wa.size() == 0) chk(0, "R11", "unexpected write", {4'h0, mem_addr}, 0);
      else begin
        int a; logic [15:0] d;
        a = exp_wa.pop_front(); d = exp_wd.pop_front();
        chk(mem_addr == a[11:0], "R3", "write address", {20'h0, mem_addr}, a);
        chk(mem_wdata == d, "R3", "write data", {16'h0, mem_wdata}, {16'h0, d});
      end
    end
    if (out_strobe) begin
      outs_seen++;
      if (exp_out.size() == 0) chk(0, "R8", "unexpected strobe", {24'h0, out_data}, 0);
      else begin
        logic [7:0] e;
        e = exp_out.pop_front();
        chk(out_data == e, "R8", "output data", {24'h0, out_data}, {24'h0, e});
      end
    end
  end

  task automatic run_model(input logic [7:0] inval);
    logic [11:0] pcm, x, p;
    logic [15:0] acm, irm;
    bit stop;
    for (int i = 0; i < 4096; i++) mm[i] = mem[i];
    pcm = 0; acm = 0; stop = 0;
    for (int n = 0; n < 2000 && !stop; n++) begin
      irm = mm[pcm]; pcm = pcm + 1; x = irm[11:0]; p = mm[x][11:0];
      case (irm[15:12])
        4'h0: begin mm[x] = {4'h0, pcm}; exp_wa.push_back(x); exp_wd.push_back({4'h0, pcm}); pcm = x + 1; end
        4'h1: acm = mm[x];
        4'h2: begin mm[x] = acm; exp_wa.push_back(x); exp_wd.push_back(acm); end
        4'h3: acm = acm + mm[x];
        4'h4: acm = acm - mm[x];
        4'h5: acm = {8'h00, inval};
        4'h6: exp_out.push_back(acm[7:0]);
        4'h7: stop = 1;
        4'h8: if ((x[11:10] == 2'b00 && $signed(acm) < 0) || (x[11:10] == 2'b01 && acm == 0) ||
                  (x[11:10] == 2'b10 && $signed(acm) > 0)) pcm = pcm + 1;
        4'h9: pcm = x;
        4'hA: acm = 0;
        4'hB: acm = acm + mm[p];
        4'hC: pcm = p;
        4'hD: acm = mm[p];
        4'hE: begin mm[p] = acm; exp_wa.push_back(p); exp_wd.push_back(acm); end
        default: ;
      endcase
    end
  endtask

  task automatic run_prog(input string name, input bit use_in, input logic [7:0] inval);
    int n;
    logic [11:0] a0;
    int bad;
    exp_wa.delete(); exp_wd.delete(); exp_out.delete(); outs_seen = 0;
    in_valid = 0; in_data = inval;
    run_model(inval);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mem_we == 0 && out_strobe == 0 && halted == 0, "R1", "reset outputs",
        {29'h0, mem_we, out_strobe, halted}, 0);
    chk(mem_addr == 0, "R1", "reset address", {20'h0, mem_addr}, 0);
    rst_n = 1; mon_en = 1;
    @(negedge clk); @(negedge clk);
    chk(mem_addr == 0, "R1", "first fetch address", {20'h0, mem_addr}, 0);
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk); n++;
      if (use_in && n == 80) begin
        // R7: still stalled, nothing output before data is present
        chk(!halted && outs_seen == 0, "R7", "stall before valid", {31'h0, halted}, 0);
        in_valid = 1;
      end
    end
    chk(halted == 1, "R9", {name, " reached halt"}, {31'h0, halted}, 1);
    chk(exp_wa.size() == 0 && exp_out.size() == 0, "R5", {name, " pending events"},
        exp_wa.size() + exp_out.size(), 0);
    a0 = mem_addr;
    repeat (20) @(negedge clk);
    chk(halted == 1 && mem_addr == a0, "R9", "frozen after halt", {20'h0, mem_addr}, {20'h0, a0});
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== mm[i]) bad++;
    chk(bad == 0, "R6", {name, " memory image"}, bad, 0);
    mon_en = 0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  initial begin
    clear_mem();
    // R3 R4 R10: arithmetic wrap, skips, clear, no-op, jump
    mem[0] = enc(1, 20);  mem[1] = enc(3, 21);  mem[2] = enc(2, 30);
    mem[3] = enc(4, 21);  mem[4] = enc(2, 31);  mem[5] = enc(8, 12'h000);
    mem[6] = enc(2, 32);  mem[7] = enc(10, 0);  mem[8] = enc(8, 12'h400);
    mem[9] = enc(2, 33);  mem[10] = enc(8, 12'h800); mem[11] = enc(6, 0);
    mem[12] = enc(1, 22); mem[13] = enc(8, 12'h800); mem[14] = enc(7, 0);
    mem[15] = enc(6, 0);  mem[16] = 16'hF000; mem[17] = enc(9, 40);
    mem[20] = 16'h7FFF;   mem[21] = 16'h0001; mem[22] = 16'h1234;
    mem[40] = enc(8, 12'hC00); mem[41] = enc(2, 34); mem[42] = enc(7, 0);
    run_prog("arith", 0, 8'h00);
    chk(mem[30] == 16'h8000, "R3", "add wraps", {16'h0, mem[30]}, 32'h8000);
    chk(mem[33] == 16'h0000 && mem[32] == 16'h7FFF, "R4", "zero skip", {16'h0, mem[32]}, 32'h7FFF);
    chk(mem[34] == 16'h1234, "R10", "no-op and code 11 skip", {16'h0, mem[34]}, 32'h1234);

    clear_mem();
    // R5 R6 R7: indirect, call/return, input
    mem[0] = enc(13, 50); mem[1] = enc(11, 51); mem[2] = enc(14, 52);
    mem[3] = enc(0, 70);  mem[4] = enc(1, 62);  mem[5] = enc(6, 0); mem[6] = enc(7, 0);
    mem[50] = 16'd60; mem[51] = 16'd61; mem[52] = 16'd62;
    mem[60] = 16'h0011; mem[61] = 16'h0022;
    mem[71] = enc(5, 0); mem[72] = enc(6, 0); mem[73] = enc(2, 63); mem[74] = enc(12, 70);
    run_prog("indirect", 1, 8'hC5);
    chk(mem[62] == 16'h0033, "R6", "indirect store", {16'h0, mem[62]}, 32'h33);
    chk(mem[70] == 16'h0004, "R5", "return address", {16'h0, mem[70]}, 32'h4);
    chk(mem[63] == 16'h00C5, "R7", "input zero-extended", {16'h0, mem[63]}, 32'hC5);
    chk(outs_seen == 2, "R8", "strobe count", outs_seen, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule